// File: doc/BRIEF.md
# Interrupt Aggregator with Global Enable

This block gathers single-cycle event pulses from a serial peripheral into a sticky status register. Software acknowledges pending events by writing ones to the bits it wants cleared. A per-source enable register masks the status, and one global enable bit gates the masked result. The combined value drives a single registered interrupt line.

The same register space holds a software reset register. Writing one exact key value to it raises a reset pulse of fixed length toward the attached core. While that pulse is high, the status register is held at zero. Any other value written to the reset register does nothing.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, every readable register reads zero, `irq_out` is low and `core_rst_out` is low.
- R2: A high level on `evt_in[i]` at a clock edge sets status bit i (read at offset 0x20), and the bit stays set until it is cleared. The sources are: bit 0 mode fault, bit 1 slave-select fault, bit 2 transmit empty, bit 3 transmit underrun, bit 4 receive full, bit 5 receive overrun, bit 6 transmit half empty.
- R3: A write to offset 0x20 clears each status bit whose data bit is 1 and leaves the bits written as 0 unchanged.
- R4: If an event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: The enable register at offset 0x28 holds bits 6:0, reads back what was written, and reads zero in the upper bits. Writing 0 to it masks every source.
- R6: The global enable is bit 31 of offset 0x1C, and the other bits of that register read zero. While bit 31 is 0, `irq_out` stays low whatever the status.
- R7: `irq_out` equals the global enable ANDed with the OR of (status AND enable), and it takes its new value at the same clock edge as the registers that feed it.
- R8: Writing 0x0000000A to offset 0x40 drives `core_rst_out` high for exactly RST_CYCLES cycles (default 4), starting at the edge of the write. Offset 0x40 reads as zero.
- R9: Writing any other value to offset 0x40 gives no pulse and leaves the status unchanged.
- R10: From the key write until the pulse ends, the status is zero and events are dropped. The enable register and the global enable keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register bus |
| reg_addr | input | ADDR_W (8) | Byte offset, used for both writes and reads |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data for `reg_addr`, combinational |
| evt_in | input | N_SRC (7) | One-cycle event pulses, one per source |
| irq_out | output | 1 | Registered interrupt request |
| core_rst_out | output | 1 | Reset pulse to the attached core |

## Verification
A status bit that gets lost or sticks shows up at once in a read of offset 0x20. It also shows on `irq_out` in the cycle after the edge that caused it, but only when that source and the global enable are both on. A faulty reset counter changes the pulse length seen on `core_rst_out`. The bench therefore samples that output after every edge of the pulse and one edge past it. A bad key decode shows as a pulse, or a cleared status, after a write of a value that is not the key.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam logic [7:0] OFS_GIE  = 8'h1C;
    localparam logic [7:0] OFS_STAT = 8'h20;
    localparam logic [7:0] OFS_IEN  = 8'h28;
    localparam logic [7:0] OFS_SRST = 8'h40;
    localparam int unsigned SRST_KEY = 32'h0000_000A;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_GIE,
        SEL_STAT,
        SEL_IEN,
        SEL_SRST
    } reg_sel_e;

    function automatic reg_sel_e decode_sel(input logic [7:0] a);
        case (a)
            OFS_GIE:  return SEL_GIE;
            OFS_STAT: return SEL_STAT;
            OFS_IEN:  return SEL_IEN;
            OFS_SRST: return SEL_SRST;
            default:  return SEL_NONE;
        endcase
    endfunction
endpackage

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
    parameter int N_SRC = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] evt_i,
    input  logic [N_SRC-1:0] ack_mask_i,
    input  logic             clr_all_i,
    output logic [N_SRC-1:0] stat_o,
    output logic [N_SRC-1:0] stat_next_o
);
    typedef struct packed {
        logic [N_SRC-1:0] stat;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N_SRC; i++) begin
            if (clr_all_i)
                st_d.stat[i] = 1'b0;
            else if (evt_i[i])
                st_d.stat[i] = 1'b1;
            else if (ack_mask_i[i])
                st_d.stat[i] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_o      = st_q.stat;
    assign stat_next_o = st_d.stat;

    AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_all_i && (evt_i != '0)) |=> ((stat_o & $past(evt_i)) == $past(evt_i))); // R4
    AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_all_i && (evt_i == '0) && (ack_mask_i == '0)) |=> $stable(stat_o)); // R2
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_all_i && ((ack_mask_i & ~evt_i) != '0)) |=> ((stat_o & $past(ack_mask_i & ~evt_i)) == '0)); // R3
endmodule

// File: rtl/irq_rst_pulse.sv
module irq_rst_pulse #(
    parameter int RST_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic key_hit_i,
    output logic pulse_o
);
    localparam int CNT_W = $clog2(RST_CYCLES + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pulse_t;

    pulse_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (key_hit_i)
            p_d.cnt = CNT_W'(RST_CYCLES);
        else if (p_q.cnt != '0)
            p_d.cnt = p_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign pulse_o = (p_q.cnt != '0);

    AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
        key_hit_i |=> pulse_o); // R8
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!key_hit_i && !pulse_o) |=> !pulse_o); // R9
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int N_SRC      = 7,
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 8,
    parameter int RST_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [N_SRC-1:0]  evt_in,
    output logic              irq_out,
    output logic              core_rst_out
);
    localparam int GIE_BIT = DATA_W - 1;

    typedef struct packed {
        logic             gie;
        logic [N_SRC-1:0] en;
        logic             irq;
    } ctl_t;

    ctl_t             r_d, r_q;
    reg_sel_e         sel;
    logic [N_SRC-1:0] stat, stat_next, ack_mask;
    logic             key_hit, pulse;

    assign sel      = decode_sel(8'(reg_addr));
    assign key_hit  = reg_wr && (sel == SEL_SRST) && (reg_wdata == DATA_W'(SRST_KEY));
    assign ack_mask = (reg_wr && (sel == SEL_STAT)) ? reg_wdata[N_SRC-1:0] : '0;

    irq_sticky_bank #(.N_SRC(N_SRC)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       (evt_in),
        .ack_mask_i  (ack_mask),
        .clr_all_i   (key_hit | pulse),
        .stat_o      (stat),
        .stat_next_o (stat_next)
    );

    irq_rst_pulse #(.RST_CYCLES(RST_CYCLES)) u_pulse (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_hit_i (key_hit),
        .pulse_o   (pulse)
    );

    always_comb begin
        r_d = r_q;
        if (reg_wr && (sel == SEL_GIE)) r_d.gie = reg_wdata[GIE_BIT];
        if (reg_wr && (sel == SEL_IEN)) r_d.en  = reg_wdata[N_SRC-1:0];
        r_d.irq = r_d.gie && ((stat_next & r_d.en) != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (sel)
            SEL_GIE:  reg_rdata[GIE_BIT] = r_q.gie;
            SEL_STAT: reg_rdata = DATA_W'(stat);
            SEL_IEN:  reg_rdata = DATA_W'(r_q.en);
            default:  reg_rdata = '0;
        endcase
    end

    assign irq_out      = r_q.irq;
    assign core_rst_out = pulse;

    AST_GIE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.gie |-> !irq_out); // R6
    AST_RST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst_out |-> (stat == '0)); // R10
    AST_MASK_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.en == '0) |-> !irq_out); // R5
endmodule

// File: tb/irq_aggregator_test.sv
`timescale 1ns/100ps
module irq_aggregator_test;
    localparam int N = 12;
    // Vector layout: {evt[6:0], wr, addr[7:0], wdata[31:0], exp_stat[6:0], exp_irq}
    localparam logic [55:0] VEC [N] = '{
        {7'h00, 1'b1, 8'h28, 32'h0000_0005, 7'h00, 1'b0},  // R5 enable bits 0,2
        {7'h04, 1'b0, 8'h20, 32'h0000_0000, 7'h04, 1'b0},  // R2 R6 global off
        {7'h00, 1'b1, 8'h1C, 32'h8000_0000, 7'h04, 1'b1},  // R7 global on
        {7'h10, 1'b0, 8'h20, 32'h0000_0000, 7'h14, 1'b1},  // R2
        {7'h00, 1'b1, 8'h20, 32'h0000_0004, 7'h10, 1'b0},  // R3 R5
        {7'h01, 1'b1, 8'h20, 32'h0000_0001, 7'h11, 1'b1},  // R4
        {7'h00, 1'b1, 8'h20, 32'h0000_007F, 7'h00, 1'b0},  // R3
        {7'h40, 1'b0, 8'h20, 32'h0000_0000, 7'h40, 1'b0},  // R2 masked
        {7'h00, 1'b1, 8'h28, 32'h0000_007F, 7'h40, 1'b1},  // R7
        {7'h00, 1'b1, 8'h28, 32'h0000_0000, 7'h40, 1'b0},  // R5 all masked
        {7'h00, 1'b1, 8'h28, 32'h0000_0040, 7'h40, 1'b1},  // R7
        {7'h00, 1'b1, 8'h1C, 32'h7FFF_FFFF, 7'h40, 1'b0}   // R6 bit31 low
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h20;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [6:0]  evt_in = '0;
    logic        irq_out, core_rst_out;
    int          n_chk = 0, n_err = 0;
    logic [31:0] rv;

    always #2 clk = ~clk;

    irq_aggregator uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in),
        .irq_out(irq_out), .core_rst_out(core_rst_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock edge with the given stimulus, then leave the bus reading status.
    task automatic step(input logic [6:0] e, input logic w, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        evt_in = e; reg_wr = w; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #0.5;
        evt_in = '0; reg_wr = 1'b0; reg_addr = 8'h20; reg_wdata = '0;
        #0.5;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = a;
        #0.5;
        v = reg_rdata;
    endtask

    initial begin
        #80000;
        n_chk++; n_err++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        rd(8'h1C, rv); chk("R1 gie", rv, 32'h0);
        rd(8'h20, rv); chk("R1 stat", rv, 32'h0);
        rd(8'h28, rv); chk("R1 ien", rv, 32'h0);
        chk("R1 irq", {31'b0, irq_out}, 32'h0);
        chk("R1 rst", {31'b0, core_rst_out}, 32'h0);

        for (int i = 0; i < N; i++) begin
            step(VEC[i][55:49], VEC[i][48], VEC[i][47:40], VEC[i][39:8]);
            chk($sformatf("R2/R7 vec%0d stat", i), reg_rdata, {25'b0, VEC[i][7:1]});
            chk($sformatf("R7 vec%0d irq", i), {31'b0, irq_out}, {31'b0, VEC[i][0]});
        end

        // R6 only bit 31 is kept
        rd(8'h1C, rv); chk("R6 gie readback", rv, 32'h0);
        // R5 upper bits dropped
        step(7'h00, 1'b1, 8'h28, 32'hFFFF_FFFF);
        rd(8'h28, rv); chk("R5 ien readback", rv, 32'h7F);
        step(7'h00, 1'b1, 8'h28, 32'h0000_0040);
        step(7'h00, 1'b1, 8'h1C, 32'h8000_0000);
        chk("R7 irq restored", {31'b0, irq_out}, 32'h1);

        // R9 non-key write ignored
        step(7'h00, 1'b1, 8'h40, 32'h0000_00A0);
        chk("R9 no pulse", {31'b0, core_rst_out}, 32'h0);
        chk("R9 stat kept", reg_rdata, 32'h40);
        rd(8'h40, rv); chk("R8 srst reads zero", rv, 32'h0);

        // R8 R10 key write
        step(7'h00, 1'b1, 8'h40, 32'h0000_000A);
        chk("R8 pulse edge0", {31'b0, core_rst_out}, 32'h1);
        chk("R10 stat cleared", reg_rdata, 32'h0);
        chk("R10 irq low", {31'b0, irq_out}, 32'h0);
        for (int k = 1; k < 4; k++) begin
            step(7'h7F, 1'b0, 8'h20, 32'h0);
            chk($sformatf("R8 pulse edge%0d", k), {31'b0, core_rst_out}, 32'h1);
            chk($sformatf("R10 evt dropped %0d", k), reg_rdata, 32'h0);
        end
        step(7'h00, 1'b0, 8'h20, 32'h0);
        chk("R8 pulse ended", {31'b0, core_rst_out}, 32'h0);
        step(7'h40, 1'b0, 8'h20, 32'h0);
        chk("R10 stat after pulse", reg_rdata, 32'h40);
        chk("R10 enables kept", {31'b0, irq_out}, 32'h1);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule